// File: doc/BRIEF.md
# Special Register Access Unit

This block serves the move-to-special-register and move-from-special-register operations of a small microcontroller core. An 8-bit selector picks one special register. A privilege flag qualifies the access, and separate read and write strobes carry it out. The unit holds the condition flags, two physical stack-pointer registers, the PRIMASK and FAULTMASK single-bit masks, the base priority and the two-bit CONTROL register.

Read data is combinational from the selector and the current state. Writes take effect at the next rising clock edge. When the stack-select bit of CONTROL changes, the two physical stack registers exchange contents. This keeps the active stack pointer output on the selected architectural stack. A separate exception-exit input clears the fault mask on return from any exception other than the non-maskable one.

The instruction decoder drives the selector and data. The core datapath uses `sp_active` as its stack pointer and takes the mask and CONTROL outputs directly.

Top module: `sreg_access_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, all state clears: flags, both stack registers, PRIMASK, FAULTMASK, base priority and CONTROL read zero, and `acc_err` is low.
- R2: Selectors 0 to 7 are status views. The read returns the flags in bits 31:27 when selector bit 2 is 0. It returns `cur_exc` in bits 8:0 when selector bit 0 is 1 and `acc_priv` is 1. All other bits read 0, so the execution-state field is always zero.
- R3: With `acc_priv` low, a read of any selector above 7 except 20 returns 0. A read of CONTROL (20) returns its value at either privilege.
- R4: With `acc_priv` low, a write to any selector above 7 changes no state. A write to a status selector (0 to 7), at either privilege, loads only the flags, from write-data bits 31:27.
- R5: CONTROL (20) keeps write-data bit 0 (unprivileged thread) and bit 1 (stack select), and reads 0 in bits 31:2. A write that changes bit 1 exchanges `sp_active` with the banked stack register at the same edge.
- R6: Selector 8 is the main stack pointer and selector 9 the process stack pointer. With stack select 0, the main pointer is the active register and the process pointer is the banked one. With stack select 1 the roles swap. Reads and privileged writes follow this mapping, and `sp_active` always shows the selected architectural pointer.
- R7: PRIMASK (16) and FAULTMASK (19) each hold write-data bit 0. Base priority (17) holds the low PRIO_W write-data bits. Each reads back zero-extended.
- R8: When `exc_exit` is high at an edge, FAULTMASK clears unless `exc_ret_num` equals 2. The clear wins over a FAULTMASK write in the same cycle. A return with number 2 leaves FAULTMASK unchanged.
- R9: Selectors 10 to 15, 18 and 21 to 255 are unknown. They read 0 and ignore writes. An access strobe to one of them (read or write) drives `acc_err` high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_sel | input | 8 | Special register selector |
| acc_priv | input | 1 | Access is privileged |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | DW | Write data |
| cur_exc | input | EXC_W | Currently active exception number |
| exc_exit | input | 1 | Exception return event |
| exc_ret_num | input | EXC_W | Number of the exception being returned from |
| acc_rdata | output | DW | Masked read data |
| acc_err | output | 1 | One-cycle pulse after an access to an unknown selector |
| sp_active | output | DW | Active stack pointer |
| primask_o | output | 1 | PRIMASK |
| faultmask_o | output | 1 | FAULTMASK |
| basepri_o | output | PRIO_W | Base priority |
| ctrl_npriv_o | output | 1 | CONTROL unprivileged-thread bit |
| ctrl_spsel_o | output | 1 | CONTROL stack-select bit |

## Verification
The assertions watch these rules on every cycle:
- the stack exchange on a stack-select change, and the stack registers holding otherwise;
- the fault-mask clear on exit and its hold on a number-2 return;
- the error pulse and its absence;
- zero reads for unprivileged system selectors;
- unprivileged writes leaving the masks and CONTROL alone;
- zeroed flag bits for status views with selector bit 2 set.

Only the bench scenarios can show the following:
- that the main and process pointers keep their values through several stack-select changes;
- that status views merge flags and the exception number correctly;
- that written values read back through the selector mapping.

// File: rtl/sreg_pkg.sv
// Shared constants and types for the special register access unit.
// Assumes 8-bit selectors; selector codes are fixed by the instruction set.
package sreg_pkg;
    localparam logic [7:0] SEL_MSP   = 8'd8;
    localparam logic [7:0] SEL_PSP   = 8'd9;
    localparam logic [7:0] SEL_PMASK = 8'd16;
    localparam logic [7:0] SEL_BPRI  = 8'd17;
    localparam logic [7:0] SEL_FMASK = 8'd19;
    localparam logic [7:0] SEL_CTRL  = 8'd20;
    localparam int         FLAG_W    = 5;

    typedef struct packed {
        logic status;
        logic msp;
        logic psp;
        logic pmask;
        logic bpri;
        logic fmask;
        logic ctrl;
        logic unknown;
    } sel_hit_t;
endpackage

// File: rtl/sreg_decode.sv
// Selector decoder: turns the 8-bit selector into one-hot register hits.
// Assumes nothing about privilege; gating is done by the caller.
module sreg_decode
    import sreg_pkg::*;
(
    input  logic [7:0] sel,
    output sel_hit_t   hit
);
    // Compare the selector against every known register code.
    always_comb begin
        hit         = '0;
        hit.status  = (sel[7:3] == 5'd0);
        hit.msp     = (sel == SEL_MSP);
        hit.psp     = (sel == SEL_PSP);
        hit.pmask   = (sel == SEL_PMASK);
        hit.bpri    = (sel == SEL_BPRI);
        hit.fmask   = (sel == SEL_FMASK);
        hit.ctrl    = (sel == SEL_CTRL);
        hit.unknown = ~(hit.status | hit.msp | hit.psp | hit.pmask |
                        hit.bpri | hit.fmask | hit.ctrl);
    end
endmodule

// File: rtl/sreg_stack_bank.sv
// Banked stack pointer pair. One physical register is always the active
// stack; the other holds the unselected one. Assumes swap and writes are
// never requested in the same cycle (they come from different selectors).
module sreg_stack_bank #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spsel,
    input  logic          swap,
    input  logic          wr_main,
    input  logic          wr_proc,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] sp_act,
    output logic [DW-1:0] sp_bank
);
    logic wr_act;
    logic wr_bank;

    // Map architectural writes to physical registers via the stack select.
    always_comb begin
        wr_act  = spsel ? wr_proc : wr_main;
        wr_bank = spsel ? wr_main : wr_proc;
    end

    // Physical registers: exchange on swap, otherwise load on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_act  <= '0;
            sp_bank <= '0;
        end else if (swap) begin
            sp_act  <= sp_bank;
            sp_bank <= sp_act;
        end else begin
            if (wr_act)  sp_act  <= wdata;
            if (wr_bank) sp_bank <= wdata;
        end
    end
endmodule

// File: rtl/sreg_mask_regs.sv
// Flag, mask, base priority and CONTROL storage. Write enables arrive
// already gated by privilege. The exception-exit clear of the fault mask
// takes priority over a same-cycle fault mask write.
module sreg_mask_regs
    import sreg_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_flags,
    input  logic              we_pmask,
    input  logic              we_fmask,
    input  logic              we_bpri,
    input  logic              we_ctrl,
    input  logic              fm_clear,
    input  logic [FLAG_W-1:0] wd_flags,
    input  logic              wd_bit0,
    input  logic              wd_bit1,
    input  logic [PRIO_W-1:0] wd_prio,
    output logic [FLAG_W-1:0] flags,
    output logic              pmask,
    output logic              fmask,
    output logic [PRIO_W-1:0] bpri,
    output logic [1:0]        ctrl
);
    // Condition flags load from the top data bits.
    always_ff @(posedge clk) begin
        if (!rst_n)        flags <= '0;
        else if (we_flags) flags <= wd_flags;
    end

    // PRIMASK holds a single bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        pmask <= 1'b0;
        else if (we_pmask) pmask <= wd_bit0;
    end

    // FAULTMASK: exception-exit clear beats a write.
    always_ff @(posedge clk) begin
        if (!rst_n)        fmask <= 1'b0;
        else if (fm_clear) fmask <= 1'b0;
        else if (we_fmask) fmask <= wd_bit0;
    end

    // Base priority keeps the low PRIO_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       bpri <= '0;
        else if (we_bpri) bpri <= wd_prio;
    end

    // CONTROL keeps stack select (bit 1) and unprivileged thread (bit 0).
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= 2'b00;
        else if (we_ctrl) ctrl <= {wd_bit1, wd_bit0};
    end
endmodule

// File: rtl/sreg_read_mux.sv
// Read data assembly with per-view and per-privilege masking.
// Purely combinational; assumes the hit vector is one-hot.
module sreg_read_mux
    import sreg_pkg::*;
#(
    parameter int DW     = 32,
    parameter int EXC_W  = 9,
    parameter int PRIO_W = 8
) (
    input  sel_hit_t          hit,
    input  logic              sel_b2,
    input  logic              sel_b0,
    input  logic              priv,
    input  logic [FLAG_W-1:0] flags,
    input  logic [EXC_W-1:0]  cur_exc,
    input  logic              spsel,
    input  logic [DW-1:0]     sp_act,
    input  logic [DW-1:0]     sp_bank,
    input  logic              pmask,
    input  logic              fmask,
    input  logic [PRIO_W-1:0] bpri,
    input  logic [1:0]        ctrl,
    output logic [DW-1:0]     rdata
);
    localparam int FLAG_LO = DW - FLAG_W;

    // Select and mask the read value for the addressed register.
    always_comb begin
        rdata = '0;
        if (hit.unknown) begin
            rdata = '0;
        end else if (hit.status) begin
            if (!sel_b2)          rdata[DW-1:FLAG_LO] = flags;
            if (sel_b0 && priv)   rdata[EXC_W-1:0]    = cur_exc;
        end else if (hit.ctrl) begin
            rdata[1:0] = ctrl;
        end else if (priv) begin
            if (hit.msp)   rdata = spsel ? sp_bank : sp_act;
            if (hit.psp)   rdata = spsel ? sp_act  : sp_bank;
            if (hit.pmask) rdata[0] = pmask;
            if (hit.fmask) rdata[0] = fmask;
            if (hit.bpri)  rdata[PRIO_W-1:0] = bpri;
        end
    end
endmodule

// File: rtl/sreg_access_unit.sv
// Special register access unit top. Decodes the selector, gates writes by
// privilege, holds the state, swaps stacks on a stack-select change, clears
// the fault mask on non-NMI exception exit and flags unknown selectors.
// Assumes at most one access per cycle.
module sreg_access_unit
    import sreg_pkg::*;
#(
    parameter int DW      = 32,
    parameter int EXC_W   = 9,
    parameter int PRIO_W  = 8,
    parameter int NMI_NUM = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        acc_sel,
    input  logic              acc_priv,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [DW-1:0]     acc_wdata,
    input  logic [EXC_W-1:0]  cur_exc,
    input  logic              exc_exit,
    input  logic [EXC_W-1:0]  exc_ret_num,
    output logic [DW-1:0]     acc_rdata,
    output logic              acc_err,
    output logic [DW-1:0]     sp_active,
    output logic              primask_o,
    output logic              faultmask_o,
    output logic [PRIO_W-1:0] basepri_o,
    output logic              ctrl_npriv_o,
    output logic              ctrl_spsel_o
);
    localparam int               FLAG_LO  = DW - FLAG_W;
    localparam logic [EXC_W-1:0] NMI_CODE = EXC_W'(NMI_NUM);

    sel_hit_t          hit;
    logic              wr_sys;
    logic              we_flags, we_pmask, we_fmask, we_bpri, we_ctrl;
    logic              we_msp, we_psp, swap, fm_clear;
    logic [FLAG_W-1:0] flags;
    logic [1:0]        ctrl;
    logic [DW-1:0]     sp_banked;

    sreg_decode u_decode (
        .sel (acc_sel),
        .hit (hit)
    );

    // Write enables: status views at any privilege, the rest privileged only.
    always_comb begin
        wr_sys   = acc_wr && acc_priv;
        we_flags = acc_wr && hit.status;
        we_msp   = wr_sys && hit.msp;
        we_psp   = wr_sys && hit.psp;
        we_pmask = wr_sys && hit.pmask;
        we_fmask = wr_sys && hit.fmask;
        we_bpri  = wr_sys && hit.bpri;
        we_ctrl  = wr_sys && hit.ctrl;
        swap     = we_ctrl && (acc_wdata[1] != ctrl[1]);
        fm_clear = exc_exit && (exc_ret_num != NMI_CODE);
    end

    sreg_mask_regs #(.PRIO_W(PRIO_W)) u_masks (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_flags (we_flags),
        .we_pmask (we_pmask),
        .we_fmask (we_fmask),
        .we_bpri  (we_bpri),
        .we_ctrl  (we_ctrl),
        .fm_clear (fm_clear),
        .wd_flags (acc_wdata[DW-1:FLAG_LO]),
        .wd_bit0  (acc_wdata[0]),
        .wd_bit1  (acc_wdata[1]),
        .wd_prio  (acc_wdata[PRIO_W-1:0]),
        .flags    (flags),
        .pmask    (primask_o),
        .fmask    (faultmask_o),
        .bpri     (basepri_o),
        .ctrl     (ctrl)
    );

    sreg_stack_bank #(.DW(DW)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .spsel   (ctrl[1]),
        .swap    (swap),
        .wr_main (we_msp),
        .wr_proc (we_psp),
        .wdata   (acc_wdata),
        .sp_act  (sp_active),
        .sp_bank (sp_banked)
    );

    sreg_read_mux #(.DW(DW), .EXC_W(EXC_W), .PRIO_W(PRIO_W)) u_rmux (
        .hit     (hit),
        .sel_b2  (acc_sel[2]),
        .sel_b0  (acc_sel[0]),
        .priv    (acc_priv),
        .flags   (flags),
        .cur_exc (cur_exc),
        .spsel   (ctrl[1]),
        .sp_act  (sp_active),
        .sp_bank (sp_banked),
        .pmask   (primask_o),
        .fmask   (faultmask_o),
        .bpri    (basepri_o),
        .ctrl    (ctrl),
        .rdata   (acc_rdata)
    );

    // Error pulse one cycle after any strobe to an unknown selector.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_err <= 1'b0;
        else        acc_err <= (acc_rd || acc_wr) && hit.unknown;
    end

    assign ctrl_npriv_o = ctrl[0];
    assign ctrl_spsel_o = ctrl[1];
endmodule

// File: rtl/sreg_access_checker.sv
// Property checker for sreg_access_unit, attached by bind below.
module sreg_access_checker #(
    parameter int DW      = 32,
    parameter int EXC_W   = 9,
    parameter int PRIO_W  = 8,
    parameter int NMI_NUM = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        acc_sel,
    input logic              acc_priv,
    input logic              acc_rd,
    input logic              acc_wr,
    input logic              wr_spsel,
    input logic              exc_exit,
    input logic [EXC_W-1:0]  exc_ret_num,
    input logic [DW-1:0]     acc_rdata,
    input logic              acc_err,
    input logic [DW-1:0]     sp_active,
    input logic [DW-1:0]     sp_banked,
    input logic              primask_o,
    input logic              faultmask_o,
    input logic [PRIO_W-1:0] basepri_o,
    input logic              ctrl_npriv_o,
    input logic              ctrl_spsel_o
);
    logic known, ctrl_flip, sp_write, fm_write;

    // Reference selector classification and event terms from the ports.
    always_comb begin
        known     = (acc_sel < 8'd10) || (acc_sel == 8'd16) || (acc_sel == 8'd17) ||
                    (acc_sel == 8'd19) || (acc_sel == 8'd20);
        ctrl_flip = acc_wr && acc_priv && (acc_sel == 8'd20) && (wr_spsel != ctrl_spsel_o);
        sp_write  = acc_wr && acc_priv && (acc_sel == 8'd8 || acc_sel == 8'd9);
        fm_write  = acc_wr && acc_priv && (acc_sel == 8'd19);
    end

    a_r5_stack_swap: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_flip |=> (sp_active == $past(sp_banked)) && (sp_banked == $past(sp_active)));

    a_r6_stack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_flip && !sp_write) |=> $stable(sp_active) && $stable(sp_banked));

    a_r8_exit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_exit && exc_ret_num != EXC_W'(NMI_NUM)) |=> !faultmask_o);

    a_r8_nmi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_exit && exc_ret_num == EXC_W'(NMI_NUM) && !fm_write) |=> $stable(faultmask_o));

    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_rd || acc_wr) && !known) |=> acc_err);

    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !((acc_rd || acc_wr) && !known) |=> !acc_err);

    a_r3_unpriv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_priv && acc_sel > 8'd7 && acc_sel != 8'd20) |-> (acc_rdata == '0));

    a_r4_unpriv_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !acc_priv && acc_sel > 8'd7) |=>
        $stable(primask_o) && $stable(basepri_o) && $stable(ctrl_spsel_o) && $stable(ctrl_npriv_o));

    a_r2_flag_view: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel < 8'd8 && acc_sel[2]) |-> (acc_rdata[DW-1:DW-5] == 5'd0));
endmodule

bind sreg_access_unit sreg_access_checker #(
    .DW(DW), .EXC_W(EXC_W), .PRIO_W(PRIO_W), .NMI_NUM(NMI_NUM)
) u_sreg_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_sel      (acc_sel),
    .acc_priv     (acc_priv),
    .acc_rd       (acc_rd),
    .acc_wr       (acc_wr),
    .wr_spsel     (acc_wdata[1]),
    .exc_exit     (exc_exit),
    .exc_ret_num  (exc_ret_num),
    .acc_rdata    (acc_rdata),
    .acc_err      (acc_err),
    .sp_active    (sp_active),
    .sp_banked    (sp_banked),
    .primask_o    (primask_o),
    .faultmask_o  (faultmask_o),
    .basepri_o    (basepri_o),
    .ctrl_npriv_o (ctrl_npriv_o),
    .ctrl_spsel_o (ctrl_spsel_o)
);

// File: tb/test_sreg_access_unit.sv
`timescale 1ns/1ps
module test_sreg_access_unit;
    localparam int DW = 32, EXC_W = 9, PRIO_W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] acc_sel = '0;
    logic acc_priv = 1'b0, acc_rd = 1'b0, acc_wr = 1'b0, exc_exit = 1'b0;
    logic [DW-1:0] acc_wdata = '0;
    logic [EXC_W-1:0] cur_exc = '0, exc_ret_num = '0;
    logic [DW-1:0] acc_rdata, sp_active;
    logic acc_err, primask_o, faultmask_o, ctrl_npriv_o, ctrl_spsel_o;
    logic [PRIO_W-1:0] basepri_o;

    sreg_access_unit i_sreg_access_unit (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    // Architectural model: main and process pointers kept by name.
    logic [4:0] m_flags; logic [DW-1:0] m_msp, m_psp;
    logic m_pm, m_fm; logic [PRIO_W-1:0] m_bp; logic [1:0] m_ctrl;

    task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic known_sel(logic [7:0] s);
        return (s < 8'd10) || s == 8'd16 || s == 8'd17 || s == 8'd19 || s == 8'd20;
    endfunction

    function automatic logic [DW-1:0] exp_read(logic [7:0] s, logic p, logic [EXC_W-1:0] ce);
        logic [DW-1:0] v = '0;
        if (s < 8'd8) begin
            if (!s[2]) v[31:27] = m_flags;
            if (s[0] && p) v[EXC_W-1:0] = ce;
        end else if (s == 8'd20) v = {30'd0, m_ctrl};
        else if (p) begin
            case (s)
                8'd8:  v = m_msp;
                8'd9:  v = m_psp;
                8'd16: v = {31'd0, m_pm};
                8'd17: v = {24'd0, m_bp};
                8'd19: v = {31'd0, m_fm};
                default: v = '0;
            endcase
        end
        return v;
    endfunction

    function automatic string tag_of(logic [7:0] s, logic p, logic ex);
        if (ex) return "R8";
        if (!known_sel(s)) return "R9";
        if (s < 8'd8) return "R2";
        if (s == 8'd20) return "R5";
        if (!p) return "R3";
        if (s == 8'd8 || s == 8'd9) return "R6";
        return "R7";
    endfunction

    // One access cycle: starts and ends at a falling edge.
    task automatic op(logic [7:0] s, logic p, logic rd, logic wr, logic [DW-1:0] d,
                      logic ex, logic [EXC_W-1:0] rn, logic [EXC_W-1:0] ce, string req);
        logic exp_err;
        acc_sel = s; acc_priv = p; acc_rd = rd; acc_wr = wr; acc_wdata = d;
        exc_exit = ex; exc_ret_num = rn; cur_exc = ce;
        #1;
        check(req, "rdata", acc_rdata, exp_read(s, p, ce));
        @(posedge clk);
        if (wr) begin
            if (s < 8'd8) m_flags = d[31:27];              // R4 flags-only
            else if (p) begin
                case (s)
                    8'd8:  m_msp = d;
                    8'd9:  m_psp = d;
                    8'd16: m_pm = d[0];
                    8'd17: m_bp = d[PRIO_W-1:0];
                    8'd19: m_fm = d[0];
                    8'd20: m_ctrl = d[1:0];
                    default: ;
                endcase
            end
        end
        if (ex && rn != 9'd2) m_fm = 1'b0;
        exp_err = (rd || wr) && !known_sel(s);
        @(negedge clk);
        acc_rd = 1'b0; acc_wr = 1'b0; exc_exit = 1'b0;
        check(req, "acc_err", {31'd0, acc_err}, {31'd0, exp_err});
        check(req, "sp_active", sp_active, m_ctrl[1] ? m_psp : m_msp);
        check(req, "masks", {29'd0, primask_o, faultmask_o, 1'b0}, {29'd0, m_pm, m_fm, 1'b0});
        check(req, "basepri", {24'd0, basepri_o}, {24'd0, m_bp});
        check(req, "control", {30'd0, ctrl_spsel_o, ctrl_npriv_o}, {30'd0, m_ctrl});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_flags = '0; m_msp = '0; m_psp = '0; m_pm = 0; m_fm = 0; m_bp = '0; m_ctrl = '0;
        void'($urandom(32'h5A17_C0DE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        check("R1", "sp_active", sp_active, '0);
        check("R1", "acc_err", {31'd0, acc_err}, '0);
        check("R1", "masks", {30'd0, primask_o, faultmask_o}, '0);
        check("R1", "control", {30'd0, ctrl_spsel_o, ctrl_npriv_o}, '0);
        op(8'd3, 1, 1, 0, '0, 0, '0, 9'h1AB, "R1");

        // R6/R5: banking across stack-select changes
        op(8'd8, 1, 0, 1, 32'hAAAA_0000, 0, '0, '0, "R6");
        op(8'd9, 1, 0, 1, 32'hBBBB_0000, 0, '0, '0, "R6");
        op(8'd20, 1, 0, 1, 32'h2, 0, '0, '0, "R5");
        op(8'd8, 1, 1, 0, '0, 0, '0, '0, "R6");
        op(8'd9, 1, 0, 1, 32'hCCCC_0000, 0, '0, '0, "R6");
        op(8'd20, 1, 0, 1, 32'hFFFF_FFFD, 0, '0, '0, "R5");
        op(8'd20, 0, 1, 0, '0, 0, '0, '0, "R3");
        op(8'd9, 1, 1, 0, '0, 0, '0, '0, "R6");
        op(8'd20, 1, 0, 1, 32'h0, 0, '0, '0, "R5");

        // R2/R4: status views and flag-only writes
        op(8'd0, 0, 0, 1, 32'hFFFF_FFFF, 0, '0, '0, "R4");
        op(8'd0, 0, 1, 0, '0, 0, '0, 9'h1AB, "R2");
        op(8'd1, 0, 1, 0, '0, 0, '0, 9'h1AB, "R2");
        op(8'd1, 1, 1, 0, '0, 0, '0, 9'h1AB, "R2");
        op(8'd5, 1, 1, 0, '0, 0, '0, 9'h1AB, "R2");
        op(8'd4, 1, 1, 0, '0, 0, '0, 9'h1AB, "R2");

        // R4/R3: unprivileged system access
        op(8'd16, 0, 0, 1, 32'h1, 0, '0, '0, "R4");
        op(8'd8, 0, 0, 1, 32'h1234_5678, 0, '0, '0, "R4");
        op(8'd8, 0, 1, 0, '0, 0, '0, '0, "R3");

        // R7: mask widths
        op(8'd17, 1, 0, 1, 32'h0000_01FF, 0, '0, '0, "R7");
        op(8'd17, 1, 1, 0, '0, 0, '0, '0, "R7");
        op(8'd16, 1, 0, 1, 32'hFFFF_FFFE, 0, '0, '0, "R7");

        // R8: fault mask on exception exit
        op(8'd19, 1, 0, 1, 32'h1, 0, '0, '0, "R8");
        op(8'd0, 1, 0, 0, '0, 1, 9'd2, '0, "R8");
        op(8'd0, 1, 0, 0, '0, 1, 9'd3, '0, "R8");
        op(8'd19, 1, 0, 1, 32'h1, 1, 9'd5, '0, "R8");

        // R9: unknown selectors
        op(8'd18, 1, 1, 1, 32'hFFFF_FFFF, 0, '0, '0, "R9");
        op(8'd255, 0, 1, 0, '0, 0, '0, '0, "R9");
        op(8'd10, 1, 0, 0, '0, 0, '0, '0, "R9");

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] s; logic p, ex; logic [EXC_W-1:0] rn;
            case ($urandom % 6)
                0: s = 8'($urandom % 8);
                1: s = 8'(8 + $urandom % 2);
                2: s = ($urandom % 2) ? 8'd16 : (($urandom % 2) ? 8'd17 : 8'd19);
                3: s = 8'd20;
                4: s = 8'($urandom);
                default: s = 8'(8 + $urandom % 16);
            endcase
            p  = ($urandom % 4) != 0;
            ex = ($urandom % 8) == 0;
            rn = ($urandom % 2) ? 9'd2 : 9'($urandom);
            op(s, p, 1'($urandom), 1'($urandom), $urandom, ex, rn, 9'($urandom),
               tag_of(s, p, ex));
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule